// File: doc/BRIEF.md
# Half to Single Precision Widener

This block converts a 16-bit half-precision floating-point value into the single-precision value that equals it. Every half value can be written exactly in single precision, so no rounding takes place. The result and a flag are registered, and they appear one clock after the input is applied.

A mode input selects how the top exponent code is read. In standard IEEE mode, exponent code 31 encodes infinities and NaNs. In the alternative mode the format has no infinity and no NaN, and code 31 is an ordinary exponent that extends the range by one binade.

The block sorts each input into one of these classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. A subnormal is normalized with a leading-one search. A NaN is always made quiet on output. A signalling NaN raises an invalid-operation flag.

Top module: `half_widen`

## Requirements
- R1: The input is split into sign (bit 15), exponent (bits 14:10) and fraction (bits 9:0). For a normal input (exponent 1 to 30, or 1 to 31 in the alternative mode), the output sign equals the input sign, the output exponent (bits 30:23) equals the input exponent plus 112, and the output bits 22:13 hold the input fraction while bits 12:0 are zero.
- R2: In IEEE mode (altMode = 0), an input with exponent 31 and a zero fraction gives an infinity: output exponent 255, output fraction 0, sign kept.
- R3: In IEEE mode, an input with exponent 31 and a nonzero fraction gives output exponent 255. Output bits 22:13 hold the input fraction with its bit 9 forced to 1, and bits 12:0 are zero.
- R4: invalidFlag is 1 only for an IEEE-mode input with exponent 31, a nonzero fraction and fraction bit 9 equal to 0. For every other input it is 0.
- R5: In the alternative mode (altMode = 1), exponent 31 is not special. It gives output exponent 143 with the fraction widened as in R1, and invalidFlag stays 0.
- R6: An input with exponent 0 and fraction 0 gives a single-precision zero with the input sign.
- R7: An input with exponent 0 and a nonzero fraction is normalized. If its highest set fraction bit is at position p (0 to 9), the output exponent is 103+p. Output bits 22:13 hold the fraction shifted left by 10-p and truncated to 10 bits, so the leading one is dropped. Bits 12:0 are zero.
- R8: Outputs are registered with one clock of latency. While rstN is low, singleOut and invalidFlag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfIn | input | 16 | Half-precision operand |
| altMode | input | 1 | 1 selects the alternative format with no infinity or NaN |
| singleOut | output | 32 | Single-precision result, one cycle after the input |
| invalidFlag | output | 1 | Signalling NaN seen, one cycle after the input |

## Verification
Every one of the 65536 half codes is applied in both modes, and each result is compared with a behavioural model.

The sweep covers several patterns, and each one separates a different path:
- Zeros of both signs test sign retention on the zero path.
- Subnormals with the leading one at each of the ten positions test the shift count and the exponent decrement.
- Code-31 inputs in IEEE mode separate infinity, quiet NaN and signalling NaN.
- The same code-31 inputs in the alternative mode show that no special case leaks into the ordinary path.

Reset values and the one-cycle latency are checked separately. The latency check confirms that a new input does not appear at the output before the clock edge.

// File: rtl/half_widen_pkg.sv
package half_widen_pkg;
  parameter int HALF_EXP_W  = 5;
  parameter int HALF_FRAC_W = 10;
  parameter int SGL_EXP_W   = 8;
  parameter int SGL_FRAC_W  = 23;

  typedef struct packed {
    logic isZero;
    logic isSub;
    logic isInf;
    logic isNan;
    logic isSnan;
  } ctlStrobes_t;
endpackage

// File: rtl/half_widen_ctl.sv
module half_widen_ctl
  import half_widen_pkg::*;
#(
  parameter int EXP_W  = HALF_EXP_W,
  parameter int FRAC_W = HALF_FRAC_W
) (
  input  logic [EXP_W-1:0]  expIn,
  input  logic [FRAC_W-1:0] fracIn,
  input  logic              altMode,
  output ctlStrobes_t       strobes
);
  logic topCode, expZero, fracZero, special;

  always_comb begin
    topCode  = &expIn;
    expZero  = ~|expIn;
    fracZero = ~|fracIn;
    special  = topCode & ~altMode;
    strobes.isZero = expZero & fracZero;
    strobes.isSub  = expZero & ~fracZero;
    strobes.isInf  = special & fracZero;
    strobes.isNan  = special & ~fracZero;
    strobes.isSnan = special & ~fracZero & ~fracIn[FRAC_W-1];
  end
endmodule

// File: rtl/half_widen_dp.sv
module half_widen_dp
  import half_widen_pkg::*;
#(
  parameter int IN_EXP_W   = HALF_EXP_W,
  parameter int IN_FRAC_W  = HALF_FRAC_W,
  parameter int OUT_EXP_W  = SGL_EXP_W,
  parameter int OUT_FRAC_W = SGL_FRAC_W
) (
  input  logic                            signIn,
  input  logic [IN_EXP_W-1:0]             expIn,
  input  logic [IN_FRAC_W-1:0]            fracIn,
  input  ctlStrobes_t                     strobes,
  output logic [OUT_EXP_W+OUT_FRAC_W:0]   resultOut
);
  localparam int PAD_W      = OUT_FRAC_W - IN_FRAC_W;
  localparam int BIAS_DELTA = (2**(OUT_EXP_W-1) - 1) - (2**(IN_EXP_W-1) - 1);
  localparam int POS_W      = $clog2(IN_FRAC_W + 1);

  logic [POS_W-1:0]      leadPos;
  logic [POS_W-1:0]      shiftAmt;
  logic [IN_FRAC_W-1:0]  subFrac;
  logic [IN_FRAC_W-1:0]  nanFrac;
  logic [OUT_EXP_W-1:0]  subExp;
  logic [OUT_EXP_W-1:0]  normExp;

  // leading-one search: highest set bit wins
  always_comb begin
    leadPos = '0;
    for (int i = 0; i < IN_FRAC_W; i++) begin
      if (fracIn[i]) leadPos = POS_W'(i);
    end
  end

  always_comb begin
    shiftAmt = POS_W'(IN_FRAC_W) - leadPos;
    subFrac  = fracIn << shiftAmt;
    subExp   = OUT_EXP_W'(BIAS_DELTA + 1) - OUT_EXP_W'(shiftAmt);
    normExp  = OUT_EXP_W'(expIn) + OUT_EXP_W'(BIAS_DELTA);
    nanFrac  = fracIn;
    nanFrac[IN_FRAC_W-1] = 1'b1;
  end

  always_comb begin
    if (strobes.isZero)
      resultOut = {signIn, {(OUT_EXP_W+OUT_FRAC_W){1'b0}}};
    else if (strobes.isInf)
      resultOut = {signIn, {OUT_EXP_W{1'b1}}, {OUT_FRAC_W{1'b0}}};
    else if (strobes.isNan)
      resultOut = {signIn, {OUT_EXP_W{1'b1}}, nanFrac, {PAD_W{1'b0}}};
    else if (strobes.isSub)
      resultOut = {signIn, subExp, subFrac, {PAD_W{1'b0}}};
    else
      resultOut = {signIn, normExp, fracIn, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/half_widen.sv
module half_widen
  import half_widen_pkg::*;
#(
  parameter int IN_EXP_W   = HALF_EXP_W,
  parameter int IN_FRAC_W  = HALF_FRAC_W,
  parameter int OUT_EXP_W  = SGL_EXP_W,
  parameter int OUT_FRAC_W = SGL_FRAC_W,
  localparam int IN_W      = 1 + IN_EXP_W + IN_FRAC_W,
  localparam int OUT_W     = 1 + OUT_EXP_W + OUT_FRAC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IN_W-1:0]  halfIn,
  input  logic             altMode,
  output logic [OUT_W-1:0] singleOut,
  output logic             invalidFlag
);
  logic                 signIn;
  logic [IN_EXP_W-1:0]  expIn;
  logic [IN_FRAC_W-1:0] fracIn;
  ctlStrobes_t          strobes;
  logic [OUT_W-1:0]     resultNext;

  assign signIn = halfIn[IN_W-1];
  assign expIn  = halfIn[IN_W-2 -: IN_EXP_W];
  assign fracIn = halfIn[IN_FRAC_W-1:0];

  half_widen_ctl #(.EXP_W(IN_EXP_W), .FRAC_W(IN_FRAC_W)) ctl (
    .expIn(expIn), .fracIn(fracIn), .altMode(altMode), .strobes(strobes)
  );

  half_widen_dp #(
    .IN_EXP_W(IN_EXP_W), .IN_FRAC_W(IN_FRAC_W),
    .OUT_EXP_W(OUT_EXP_W), .OUT_FRAC_W(OUT_FRAC_W)
  ) dp (
    .signIn(signIn), .expIn(expIn), .fracIn(fracIn),
    .strobes(strobes), .resultOut(resultNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      singleOut   <= '0;
      invalidFlag <= 1'b0;
    end else begin
      singleOut   <= resultNext;
      invalidFlag <= strobes.isSnan;
    end
  end
endmodule

// File: rtl/half_widen_checker.sv
module half_widen_checker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] halfIn,
  input logic        altMode,
  input logic [31:0] singleOut,
  input logic        invalidFlag
);
  logic topIeee;
  assign topIeee = (halfIn[14:10] == 5'h1F) && !altMode;

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    halfIn[15] |=> singleOut[31]); // R1
  AST_INF_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (topIeee && halfIn[9:0] == 10'h0) |=> (singleOut[30:0] == 31'h7F80_0000)); // R2
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (topIeee && halfIn[9:0] != 10'h0) |=> (singleOut[30:22] == 9'h1FF)); // R3
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (topIeee && halfIn[9:0] != 10'h0 && !halfIn[9]) |=> invalidFlag); // R4
  AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !(topIeee && halfIn[9:0] != 10'h0 && !halfIn[9]) |=> !invalidFlag); // R4
  AST_ALT_FINITE: assert property (@(posedge clk) disable iff (!rstN)
    altMode |=> (singleOut[30:23] != 8'hFF)); // R5
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (halfIn[14:0] == 15'h0) |=> (singleOut[30:0] == 31'h0)); // R6
  AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (halfIn[14:10] == 5'h0 && halfIn[9:0] != 10'h0)
      |=> (singleOut[30:23] >= 8'd103 && singleOut[30:23] <= 8'd112 && singleOut[12:0] == 13'h0)); // R7
endmodule

bind half_widen half_widen_checker chk (
  .clk(clk), .rstN(rstN), .halfIn(halfIn), .altMode(altMode),
  .singleOut(singleOut), .invalidFlag(invalidFlag)
);

// File: tb/half_widen_test.sv
`timescale 1ns/1ps
module half_widen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] halfIn = '0;
  logic        altMode = 1'b0;
  logic [31:0] singleOut;
  logic        invalidFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  half_widen uut (
    .clk(clk), .rstN(rstN), .halfIn(halfIn), .altMode(altMode),
    .singleOut(singleOut), .invalidFlag(invalidFlag)
  );

  function automatic logic [32:0] refConv(input logic [15:0] h, input logic alt);
    logic s; int e; int f; int k; int m;
    logic [31:0] o; logic inv;
    s = h[15]; e = int'(h[14:10]); f = int'(h[9:0]); inv = 1'b0;
    if (e == 31 && !alt) begin
      if (f == 0) o = {s, 8'hFF, 23'h0};
      else begin
        o = {s, 8'hFF, (h[9:0] | 10'h200), 13'h0};
        inv = !h[9];
      end
    end else if (e == 0 && f == 0) begin
      o = {s, 31'h0};
    end else if (e == 0) begin
      m = f; k = 0;
      while (m < 1024) begin m = m * 2; k++; end
      o = {s, 8'(113 - k), 10'(m), 13'h0};
    end else begin
      o = {s, 8'(e + 112), h[9:0], 13'h0};
    end
    return {inv, o};
  endfunction

  function automatic string tagOf(input logic [15:0] h, input logic alt);
    if (h[14:10] == 5'h1F && alt) return "R5";
    if (h[14:10] == 5'h1F) return (h[9:0] == 0) ? "R2" : "R3/R4";
    if (h[14:10] == 0) return (h[9:0] == 0) ? "R6" : "R7";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual flag=%0b out=%08h expected flag=%0b out=%08h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R8 reset", {invalidFlag, singleOut}, 33'h0);
    @(negedge clk) rstN = 1'b1;
    // R8 latency: a new input must not show before the clock edge
    halfIn = 16'h3C00; altMode = 1'b0;
    @(posedge clk);
    @(negedge clk) halfIn = 16'hBC00;
    #1 check("R8 hold", {invalidFlag, singleOut}, {1'b0, 32'h3F80_0000});
    @(posedge clk);
    #1 check("R8 update", {invalidFlag, singleOut}, {1'b0, 32'hBF80_0000});
    // full sweep in both modes
    for (int md = 0; md < 2; md++) begin
      for (int v = 0; v < 65536; v++) begin
        logic [32:0] expect_v;
        @(negedge clk);
        halfIn = 16'(v); altMode = md[0];
        expect_v = refConv(16'(v), md[0]);
        @(posedge clk);
        #1 check(tagOf(16'(v), md[0]), {invalidFlag, singleOut}, expect_v);
      end
    end
    // directed corners with known constants
    @(negedge clk) halfIn = 16'h7D00; altMode = 1'b0;
    @(posedge clk);
    #1 check("R4 snan", {invalidFlag, singleOut}, {1'b1, 32'h7FE0_0000});
    @(negedge clk) halfIn = 16'h0001; altMode = 1'b0;
    @(posedge clk);
    #1 check("R7 min sub", {invalidFlag, singleOut}, {1'b0, 32'h3380_0000});
    @(negedge clk) halfIn = 16'h7FFF; altMode = 1'b1;
    @(posedge clk);
    #1 check("R5 alt max", {invalidFlag, singleOut}, {1'b0, 32'h47FF_E000});
    @(negedge clk) halfIn = 16'h8000; altMode = 1'b0;
    @(posedge clk);
    #1 check("R6 neg zero", {invalidFlag, singleOut}, {1'b0, 32'h8000_0000});
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule